// File: doc/BRIEF.md
# Per-Slot Transmit Bit Source Selector

This block sits at the transmit edge of a framed serial port and decides, time slot by time slot, where each outgoing bit comes from. A frame holds 32 slots of 8 bits, sent most significant bit first. For every slot the block chooses one of four sources: the HDLC transmitter stream, a test pattern stream from a bit error rate generator, the receive data of the same slot looped back, or a constant idle level of all ones. The choice follows a fixed precedence. Pattern routing wins over everything. Loopback wins over normal HDLC data on an enabled slot. A disabled slot sends ones.

Each slot has a 4-bit entry in a small configuration RAM. The RAM is written through a plain write port. The entry for a slot is copied into an active register at the boundary just before that slot starts, so a slot never mixes two sources. A slot can also be set to 56 kbit/s operation. In that case the last bit of the slot is always sent as one, whatever the source. When the port runs unchannelized, the entry at address 0 governs every slot.

The block owns the slot and bit counters and presents the current position on its outputs. Upstream sources drive the data bit that belongs to that position in the same cycle. The chosen bit appears on the transmit output one clock later.

Top module: `txSlotSelector`

## Requirements
- R1: After reset, slotIdx and bitIdx are 0 and txBit is 1. bitIdx steps 0..7 on every clock. slotIdx advances when bitIdx wraps from 7 to 0, and goes from 31 back to 0.
- R2: The bit chosen for the position shown on slotIdx/bitIdx, together with the data inputs of that cycle, appears on txBit after the next rising clock edge.
- R3: An enabled slot with pattern routing and loopback both clear sends hdlcBit.
- R4: A slot with enable clear and pattern routing clear sends 1, even when its loopback bit is set.
- R5: A slot with pattern routing set sends bertBit, whatever its enable and loopback bits are.
- R6: An enabled slot with loopback set and pattern routing clear sends rxBit.
- R7: In a slot with the 56k bit set, bit position 7 (the last bit sent, the LSB) is sent as 1 for every source, including pattern data. Positions 0..6 follow R3 to R6.
- R8: While unchanMode is 1, every slot uses the configuration at address 0.
- R9: A configuration write takes effect for a slot only from the next start of that slot. The rest of a slot that is already running keeps its old source.
- R10: The configuration word has enable at bit 0, pattern routing at bit 1, loopback at bit 2 and 56k mode at bit 3. It is written to address cfgAddr on a clock edge where cfgWe is 1. Every entry resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Slot index to write |
| cfgData | input | 4 | Configuration word (see R10) |
| unchanMode | input | 1 | 1 = unchannelized, use entry 0 for all slots |
| hdlcBit | input | 1 | HDLC transmitter bit for the current position |
| bertBit | input | 1 | Test pattern bit for the current position |
| rxBit | input | 1 | Receive bit aligned to the current position |
| slotIdx | output | 5 | Current slot index |
| bitIdx | output | 3 | Current bit index within the slot, 0 = MSB |
| txBit | output | 1 | Serial transmit bit |

## Verification
Two functions can act on the same cycle: the 56k forcing of bit position 7 and pattern routing (or loopback) on the same slot. The bench sets up slots that combine the 56k bit with each source, drives random data on all three streams, and checks that position 7 always comes out as one while positions 0..6 follow the source. A second collision is a configuration write that lands in the middle of the slot it changes. The bench makes this happen at a known bit position and checks that the old source holds until the slot boundary and that the new source is used when the slot comes round in the next frame.

// File: rtl/txSlotPkg.sv
package txSlotPkg;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_HDLC = 2'd1,
    SRC_LOOP = 2'd2,
    SRC_BERT = 2'd3
  } srcSel_e;

  // packed: rate56 is bit 3, en is bit 0
  typedef struct packed {
    logic rate56;
    logic loop;
    logic bert;
    logic en;
  } chanCfg_t;

  localparam int CFG_W = $bits(chanCfg_t);

  typedef struct packed {
    srcSel_e src;
    logic    forceOne;
  } ctrlStb_t;

endpackage

// File: rtl/txSlotCtrl.sv
module txSlotCtrl
  import txSlotPkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_BITS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int BIT_W     = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              unchanMode,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [BIT_W-1:0]  bitIdx,
  output ctrlStb_t          ctrlStb
);

  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [BIT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] nextSlot;
  logic [SLOT_W-1:0] rdAddr;
  logic              lastBit;
  chanCfg_t          activeCfg;
  logic [CFG_W-1:0]  cfgMem [NUM_SLOTS];

  assign lastBit  = (bitCnt == BIT_LAST);
  assign nextSlot = (slotCnt == SLOT_LAST) ? '0 : slotCnt + SLOT_W'(1);
  assign rdAddr   = unchanMode ? '0 : nextSlot;

  // position counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      slotCnt <= '0;
    end else if (lastBit) begin
      bitCnt  <= '0;
      slotCnt <= nextSlot;
    end else begin
      bitCnt  <= bitCnt + BIT_W'(1);
    end
  end

  // per-slot configuration storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) cfgMem[i] <= '0;
    end else if (cfgWe) begin
      cfgMem[cfgAddr] <= cfgData;
    end
  end

  // copy the next slot's entry at the boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCfg <= '0;
    end else if (lastBit) begin
      activeCfg <= chanCfg_t'(cfgMem[rdAddr]);
    end
  end

  // fixed precedence: pattern > disabled idle > loopback > hdlc
  always_comb begin
    ctrlStb.forceOne = activeCfg.rate56 && lastBit;
    if (activeCfg.bert)      ctrlStb.src = SRC_BERT;
    else if (!activeCfg.en)  ctrlStb.src = SRC_IDLE;
    else if (activeCfg.loop) ctrlStb.src = SRC_LOOP;
    else                     ctrlStb.src = SRC_HDLC;
  end

  assign slotIdx = slotCnt;
  assign bitIdx  = bitCnt;

endmodule

// File: rtl/txSlotDatapath.sv
module txSlotDatapath
  import txSlotPkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctrlStb_t ctrlStb,
  input  logic     hdlcBit,
  input  logic     bertBit,
  input  logic     rxBit,
  output logic     txBit
);

  logic muxBit;
  logic nextBit;

  always_comb begin
    unique case (ctrlStb.src)
      SRC_BERT: muxBit = bertBit;
      SRC_LOOP: muxBit = rxBit;
      SRC_HDLC: muxBit = hdlcBit;
      default:  muxBit = IDLE_LEVEL;
    endcase
  end

  assign nextBit = ctrlStb.forceOne ? 1'b1 : muxBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txBit <= IDLE_LEVEL;
    else       txBit <= nextBit;
  end

endmodule

// File: rtl/txSlotSelector.sv
module txSlotSelector
  import txSlotPkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_BITS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int BIT_W     = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgAddr,
  input  logic [3:0]        cfgData,
  input  logic              unchanMode,
  input  logic              hdlcBit,
  input  logic              bertBit,
  input  logic              rxBit,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [BIT_W-1:0]  bitIdx,
  output logic              txBit
);

  ctrlStb_t ctrlStb;

  txSlotCtrl #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_BITS(SLOT_BITS),
    .SLOT_W   (SLOT_W),
    .BIT_W    (BIT_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .unchanMode(unchanMode),
    .slotIdx   (slotIdx),
    .bitIdx    (bitIdx),
    .ctrlStb   (ctrlStb)
  );

  txSlotDatapath #(
    .IDLE_LEVEL(1'b1)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrlStb(ctrlStb),
    .hdlcBit(hdlcBit),
    .bertBit(bertBit),
    .rxBit  (rxBit),
    .txBit  (txBit)
  );

endmodule

// File: rtl/txSlotSelectorChk.sv
module txSlotSelectorChk
  import txSlotPkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_BITS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int BIT_W     = $clog2(SLOT_BITS)
) (
  input logic              clk,
  input logic              rstN,
  input logic [SLOT_W-1:0] slotIdx,
  input logic [BIT_W-1:0]  bitIdx,
  input logic              txBit,
  input logic              hdlcBit,
  input logic              bertBit,
  input ctrlStb_t          ctrlStb
);

  localparam logic [BIT_W-1:0]  BLAST = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] SLAST = SLOT_W'(NUM_SLOTS - 1);

  // R1
  bit_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitIdx == BLAST) |=> (bitIdx == '0));

  // R1
  bit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitIdx != BLAST) |=> (bitIdx == BIT_W'($past(bitIdx) + 1'b1)));

  // R1
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitIdx == BLAST && slotIdx == SLAST) |=> (slotIdx == '0));

  // R7
  lsb_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.forceOne |=> txBit);

  // R7
  force_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.forceOne |-> (bitIdx == BLAST));

  // R5
  bert_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.src == SRC_BERT && !ctrlStb.forceOne) |=> (txBit == $past(bertBit)));

  // R3
  hdlc_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.src == SRC_HDLC && !ctrlStb.forceOne) |=> (txBit == $past(hdlcBit)));

  // R4
  idle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.src == SRC_IDLE) |=> txBit);

  // R9
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitIdx != '0) |-> $stable(ctrlStb.src));

endmodule

bind txSlotSelector txSlotSelectorChk #(
  .NUM_SLOTS(NUM_SLOTS),
  .SLOT_BITS(SLOT_BITS),
  .SLOT_W   (SLOT_W),
  .BIT_W    (BIT_W)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .slotIdx(slotIdx),
  .bitIdx (bitIdx),
  .txBit  (txBit),
  .hdlcBit(hdlcBit),
  .bertBit(bertBit),
  .ctrlStb(ctrlStb)
);

// File: tb/txSlotSelector_tb.sv
module txSlotSelector_tb_top;

  localparam int NS = 32;
  localparam int SB = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWe;
  logic [4:0] cfgAddr;
  logic [3:0] cfgData;
  logic       unchanMode;
  logic       hdlcBit, bertBit, rxBit;
  logic [4:0] slotIdx;
  logic [2:0] bitIdx;
  logic       txBit;

  int total = 0;
  int bad   = 0;
  logic [3:0] cfgM [NS];

  always #5 clk = ~clk;

  txSlotSelector dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .unchanMode(unchanMode), .hdlcBit(hdlcBit), .bertBit(bertBit), .rxBit(rxBit),
    .slotIdx(slotIdx), .bitIdx(bitIdx), .txBit(txBit)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // c[0]=enable c[1]=pattern c[2]=loopback c[3]=56k (R10)
  function automatic logic model(input logic [3:0] c, input int b,
                                 input logic hd, input logic be, input logic rx);
    logic v;
    if (c[1])      v = be;
    else if (!c[0]) v = 1'b1;
    else if (c[2]) v = rx;
    else           v = hd;
    if (c[3] && b == SB - 1) v = 1'b1;
    return v;
  endfunction

  task automatic writeCfg(input int a, input logic [3:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 5'(a); cfgData = d;
    cfgM[a] = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitFrameStart();
    do @(negedge clk); while (!(slotIdx == 0 && bitIdx == 0));
  endtask

  task automatic runFrame(input string req);
    logic expPrev = 1'b0;
    int s = 0, b = 0;
    waitFrameStart();
    for (int i = 0; i <= NS * SB; i++) begin
      if (i > 0) begin
        @(negedge clk);
        check({req, " R2"}, txBit, expPrev, $sformatf("slot %0d bit %0d", s, b));
      end
      if (i < NS * SB) begin
        s = slotIdx; b = bitIdx;
        if (i % 64 == 0) begin
          check("R1", slotIdx, i / SB, "slot position");
          check("R1", bitIdx, i % SB, "bit position");
        end
        hdlcBit = 1'($urandom); bertBit = 1'($urandom); rxBit = 1'($urandom);
        expPrev = model(cfgM[unchanMode ? 0 : s], b, hdlcBit, bertBit, rxBit);
      end
    end
  endtask

  task automatic testReset();
    check("R1", txBit, 1, "txBit in reset");
    check("R1", slotIdx, 0, "slotIdx in reset");
    check("R1", bitIdx, 0, "bitIdx in reset");
  endtask

  task automatic testIdle();
    // disabled slots with loopback set stay idle
    for (int s = 0; s < NS; s++) writeCfg(s, 4'b0100);
    runFrame("R4");
  endtask

  task automatic testHdlc();
    for (int s = 0; s < NS; s++) writeCfg(s, 4'b0001);
    runFrame("R3");
  endtask

  task automatic testMixed();
    for (int s = 0; s < NS; s++) begin
      case (s % 4)
        0: writeCfg(s, 4'b0010);  // pattern on a disabled slot
        1: writeCfg(s, 4'b0101);  // loopback
        2: writeCfg(s, 4'b0111);  // pattern beats loopback
        default: writeCfg(s, 4'b0001);
      endcase
    end
    runFrame("R5 R6");
  endtask

  task automatic test56k();
    for (int s = 0; s < NS; s++) begin
      case (s % 3)
        0: writeCfg(s, 4'b1010);
        1: writeCfg(s, 4'b1101);
        default: writeCfg(s, 4'b1001);
      endcase
    end
    runFrame("R7");
  endtask

  task automatic testUnchan();
    writeCfg(0, 4'b0010);
    for (int s = 1; s < NS; s++) writeCfg(s, 4'b0001);
    unchanMode = 1'b1;
    runFrame("R8");
    unchanMode = 1'b0;
  endtask

  task automatic testMidSlot();
    for (int s = 0; s < NS; s++) writeCfg(s, 4'b0001);
    waitFrameStart();
    while (!(slotIdx == 5 && bitIdx == 1)) @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 5'd5; cfgData = 4'b0010; cfgM[5] = 4'b0010;
    hdlcBit = 1'b0; bertBit = 1'b1; rxBit = 1'b1;
    for (int k = 1; k < SB; k++) begin
      @(negedge clk);
      cfgWe = 1'b0;
      check("R9", txBit, 0, $sformatf("old source kept, bit %0d", k));
    end
    while (!(slotIdx == 5 && bitIdx == 0)) @(negedge clk);
    for (int k = 0; k < SB; k++) begin
      @(negedge clk);
      check("R9 R10", txBit, 1, $sformatf("new source used, bit %0d", k));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1: act=timeout exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) cfgM[s] = 4'b0000;
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0; unchanMode = 1'b0;
    hdlcBit = 1'b0; bertBit = 1'b0; rxBit = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testIdle();
    testHdlc();
    testMixed();
    test56k();
    testUnchan();
    testMidSlot();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule